// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles the outcome of a control-transfer instruction in an integer pipeline. For each accepted instruction it works out where execution goes next, the return address for a jump-and-link, and whether the chosen target is an illegal instruction-address fault. The inputs are the current PC and the size of the instruction, either 2 or 4 bytes. The unit also takes an operation code, an immediate that the decoder has already sign-extended, two register operands and the destination register index. The register file, fetch, trap entry and prediction are outside the unit.

Two inputs set the configuration. A width-mode input makes the core act as a 32-bit machine: comparisons use the low 32 bits of each operand, sign-extended, and every computed address is sign-extended from bit 31. A compressed-enable input says whether 2-byte alignment is legal. When it is low, a target with bit 1 set traps. A conditional branch can trap only when it is taken.

Every output is registered once. `valid_o` follows `valid_i` by one clock, and the data outputs keep their values while `valid_i` is low.

Top module: `ctrl_xfer_unit`

## Requirements
- R1: For register-indirect jump (op 1), the target is rs1 + imm with bit 0 of the sum forced to 0.
- R2: When `narrow_i` is 1, both operands are compared as their low 32 bits sign-extended. The targets, the next PC and the link value are sign-extended from bit 31.
- R3: When `compressed_en_i` is 0 and a jump or taken branch has a target with bit 1 set, `misalign_o` is 1 and `bad_addr_o` carries that target. In every other case both are 0.
- R4: `link_o` is pc + 2 when `len4_i` is 0 and pc + 4 when it is 1.
- R5: The op encodings are: 0 direct jump, 1 register jump, 2 equal, 3 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal.
- R6: A branch that is not taken goes to pc + length and never raises `misalign_o`.
- R7: A taken branch and a direct jump go to pc + imm. A register jump goes to the R1 target.
- R8: On a misalignment trap, `link_we_o` is 0 and `next_pc_o` equals the pc of the faulting instruction.
- R9: `valid_o` is `valid_i` delayed by one clock. While `valid_i` is 0, all other outputs hold their values.
- R10: While `rst_ni` is low, every output is 0.
- R11: `link_we_o` is 1 only for ops 0 and 1 with a nonzero `rd_i` and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present |
| pc_i | input | XLEN | PC of the instruction |
| len4_i | input | 1 | 1: 4-byte instruction, 0: 2-byte instruction |
| op_i | input | 3 | Operation code (R5) |
| imm_i | input | XLEN | Sign-extended immediate |
| rs1_i | input | XLEN | First register operand |
| rs2_i | input | XLEN | Second register operand |
| rd_i | input | 5 | Destination register index |
| narrow_i | input | 1 | 32-bit mode |
| compressed_en_i | input | 1 | 2-byte alignment is legal |
| valid_o | output | 1 | Result present |
| next_pc_o | output | XLEN | Address of the next instruction |
| link_o | output | XLEN | Return address |
| link_we_o | output | 1 | Write the return address to rd |
| misalign_o | output | 1 | Instruction-address-misaligned trap |
| bad_addr_o | output | XLEN | Faulting target |

## Verification
A wrong condition decode shows up in the same result as a wrong `next_pc_o`, selecting either the sequential or the target address, exactly one clock after the instruction. A fault in the narrowing path shows up only when the operands differ in their upper half, or when an address crosses bit 31, so the sweep includes operands and a PC built to do both. Because results are one cycle deep and hold no state across instructions, no corruption can appear later than the next edge. A result that changes while `valid_i` is low points to a faulty hold path.

// File: rtl/ctrl_xfer_pkg.sv
package ctrl_xfer_pkg;
  typedef enum logic [2:0] {
    OP_JAL  = 3'd0,
    OP_JALR = 3'd1,
    OP_BEQ  = 3'd2,
    OP_BNE  = 3'd3,
    OP_BLT  = 3'd4,
    OP_BGE  = 3'd5,
    OP_BLTU = 3'd6,
    OP_BGEU = 3'd7
  } cx_op_e;
endpackage

// File: rtl/cxu_cond.sv
module cxu_cond
  import ctrl_xfer_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            narrow_i,
  output logic            taken_o
);
  logic [XLEN-1:0] a_w, b_w;

  generate
    if (XLEN > 32) begin : g_narrow
      assign a_w = narrow_i ? {{(XLEN-32){a_i[31]}}, a_i[31:0]} : a_i;
      assign b_w = narrow_i ? {{(XLEN-32){b_i[31]}}, b_i[31:0]} : b_i;
    end else begin : g_wide
      logic unused_w;
      assign unused_w = narrow_i;
      assign a_w = a_i;
      assign b_w = b_i;
    end
  endgenerate

  logic eq_w, lts_w, ltu_w;
  assign eq_w  = (a_w == b_w);
  assign lts_w = ($signed(a_w) < $signed(b_w));
  assign ltu_w = (a_w < b_w);

  always_comb begin
    unique case (cx_op_e'(op_i))
      OP_BEQ:  taken_o = eq_w;
      OP_BNE:  taken_o = !eq_w;
      OP_BLT:  taken_o = lts_w;
      OP_BGE:  taken_o = !lts_w;
      OP_BLTU: taken_o = ltu_w;
      OP_BGEU: taken_o = !ltu_w;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cxu_target.sv
module cxu_target
  import ctrl_xfer_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            len4_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic            narrow_i,
  output logic [XLEN-1:0] tgt_o,
  output logic [XLEN-1:0] seq_o
);
  logic [XLEN-1:0] len_w, base_w, sum_w, tgt_w, seq_w;

  assign len_w  = {{(XLEN-3){1'b0}}, len4_i, ~len4_i, 1'b0};
  assign base_w = (op_i == OP_JALR) ? rs1_i : pc_i;
  assign sum_w  = base_w + imm_i;
  // register jump drops bit 0 of the sum
  assign tgt_w  = (op_i == OP_JALR) ? {sum_w[XLEN-1:1], 1'b0} : sum_w;
  assign seq_w  = pc_i + len_w;

  generate
    if (XLEN > 32) begin : g_narrow
      assign tgt_o = narrow_i ? {{(XLEN-32){tgt_w[31]}}, tgt_w[31:0]} : tgt_w;
      assign seq_o = narrow_i ? {{(XLEN-32){seq_w[31]}}, seq_w[31:0]} : seq_w;
    end else begin : g_wide
      logic unused_w;
      assign unused_w = narrow_i;
      assign tgt_o = tgt_w;
      assign seq_o = seq_w;
    end
  endgenerate
endmodule

// File: rtl/ctrl_xfer_unit.sv
module ctrl_xfer_unit
  import ctrl_xfer_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            len4_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [4:0]      rd_i,
  input  logic            narrow_i,
  input  logic            compressed_en_i,
  output logic            valid_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_we_o,
  output logic            misalign_o,
  output logic [XLEN-1:0] bad_addr_o
);
  logic            taken_w, is_jmp_w, redirect_w, trap_w, we_w;
  logic [XLEN-1:0] tgt_w, seq_w, npc_w;

  cxu_cond #(.XLEN(XLEN)) u_cond (
    .op_i     (op_i),
    .a_i      (rs1_i),
    .b_i      (rs2_i),
    .narrow_i (narrow_i),
    .taken_o  (taken_w)
  );

  cxu_target #(.XLEN(XLEN)) u_tgt (
    .pc_i     (pc_i),
    .len4_i   (len4_i),
    .op_i     (op_i),
    .imm_i    (imm_i),
    .rs1_i    (rs1_i),
    .narrow_i (narrow_i),
    .tgt_o    (tgt_w),
    .seq_o    (seq_w)
  );

  assign is_jmp_w   = (op_i == OP_JAL) || (op_i == OP_JALR);
  assign redirect_w = is_jmp_w || taken_w;
  assign trap_w     = redirect_w && !compressed_en_i && tgt_w[1];
  assign we_w       = is_jmp_w && (rd_i != 5'd0) && !trap_w;
  assign npc_w      = trap_w ? pc_i : (redirect_w ? tgt_w : seq_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      next_pc_o  <= '0;
      link_o     <= '0;
      link_we_o  <= 1'b0;
      misalign_o <= 1'b0;
      bad_addr_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o  <= npc_w;
        link_o     <= seq_w;
        link_we_o  <= we_w;
        misalign_o <= trap_w;
        bad_addr_o <= trap_w ? tgt_w : '0;
      end
    end
  end

  p_trap_blocks_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && misalign_o |-> !link_we_o && next_pc_o == $past(pc_i));

  p_trap_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && misalign_o |-> !$past(compressed_en_i) && bad_addr_o[1]);

  p_not_taken_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && misalign_o |-> $past(is_jmp_w || taken_w));

  p_jalr_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_JALR) && !misalign_o |-> !next_pc_o[0]);

  p_x0_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && rd_i == 5'd0) |-> !link_we_o);

  p_narrow_ext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && narrow_i) && !misalign_o |->
      ((&next_pc_o[XLEN-1:31]) || !(|next_pc_o[XLEN-1:31])));

  p_valid_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
endmodule

// File: tb/ctrl_xfer_unit_test.sv
module ctrl_xfer_unit_test;
  localparam int XLEN = 64;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [XLEN-1:0] pc_i = '0, imm_i = '0, rs1_i = '0, rs2_i = '0;
  logic len4_i = 1'b0, narrow_i = 1'b0, compressed_en_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [4:0] rd_i = '0;
  logic valid_o, link_we_o, misalign_o;
  logic [XLEN-1:0] next_pc_o, link_o, bad_addr_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_xfer_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .pc_i(pc_i),
    .len4_i(len4_i), .op_i(op_i), .imm_i(imm_i), .rs1_i(rs1_i),
    .rs2_i(rs2_i), .rd_i(rd_i), .narrow_i(narrow_i),
    .compressed_en_i(compressed_en_i), .valid_o(valid_o),
    .next_pc_o(next_pc_o), .link_o(link_o), .link_we_o(link_we_o),
    .misalign_o(misalign_o), .bad_addr_o(bad_addr_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] sx32(input logic [XLEN-1:0] v);
    return {{(XLEN-32){v[31]}}, v[31:0]};
  endfunction

  function automatic logic [XLEN-1:0] opnd(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return '1;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'h0000_0001_0000_0001; // low half equals operand 1
      default: return 64'h7fff_ffff_ffff_fff3;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] immv(input int i);
    case (i)
      0: return 64'h20;
      1: return -64'sd6;
      default: return 64'h102;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] a, b, an, bn, tgt, seq, exp_np, exp_bad, pc_hold;
    logic tk, jmp, trap, exp_we;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!valid_o && !link_we_o && !misalign_o, "R10 flags", {61'd0, valid_o, link_we_o, misalign_o}, '0);
    check(next_pc_o == '0 && link_o == '0 && bad_addr_o == '0, "R10 data", next_pc_o | link_o | bad_addr_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    pc_i = 64'h0000_0000_7fff_fff0;
    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int nm = 0; nm < 2; nm++)
            for (int ce = 0; ce < 2; ce++)
              for (int ii = 0; ii < 3; ii++) begin
                a = opnd(ia); b = opnd(ib);
                valid_i = 1'b1; op_i = 3'(op); rs1_i = a; rs2_i = b;
                imm_i = immv(ii); narrow_i = nm[0]; compressed_en_i = ce[0];
                len4_i = ib[0]; rd_i = (ia == 0) ? 5'd0 : 5'd5;
                // R5 encodings, R2 narrowing of operands
                an = nm[0] ? sx32(a) : a;
                bn = nm[0] ? sx32(b) : b;
                case (op)
                  2: tk = (an == bn);
                  3: tk = (an != bn);
                  4: tk = ($signed(an) < $signed(bn));
                  5: tk = !($signed(an) < $signed(bn));
                  6: tk = (an < bn);
                  7: tk = !(an < bn);
                  default: tk = 1'b0;
                endcase
                jmp = (op < 2);
                tgt = (op == 1) ? ((a + imm_i) & ~64'h1) : (pc_i + imm_i); // R1, R7
                seq = pc_i + (len4_i ? 64'd4 : 64'd2);                    // R4
                if (nm[0]) begin tgt = sx32(tgt); seq = sx32(seq); end
                trap = (jmp || tk) && !ce[0] && tgt[1];                    // R3, R6
                exp_np = trap ? pc_i : ((jmp || tk) ? tgt : seq);          // R8
                exp_bad = trap ? tgt : '0;
                exp_we = jmp && (rd_i != 0) && !trap;                      // R11
                @(negedge clk);
                check(valid_o == 1'b1, "R9 valid", {63'd0, valid_o}, 64'd1);
                check(next_pc_o == exp_np,
                      trap ? "R8 next_pc" : (op == 1 ? "R1 next_pc" : (jmp || tk) ? "R7 next_pc" : "R6 next_pc"),
                      next_pc_o, exp_np);
                check(link_o == seq, nm[0] ? "R2 link" : "R4 link", link_o, seq);
                check(link_we_o == exp_we, "R11 link_we", {63'd0, link_we_o}, {63'd0, exp_we});
                check(misalign_o == trap, "R3 misalign", {63'd0, misalign_o}, {63'd0, trap});
                check(bad_addr_o == exp_bad, "R3 bad_addr", bad_addr_o, exp_bad);
              end
    // R9: hold while valid_i low
    pc_hold = next_pc_o;
    valid_i = 1'b0; pc_i = 64'h1234; op_i = 3'd0; imm_i = 64'h40;
    @(negedge clk);
    check(valid_o == 1'b0, "R9 valid low", {63'd0, valid_o}, '0);
    check(next_pc_o == pc_hold, "R9 hold", next_pc_o, pc_hold);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule